// File: doc/BRIEF.md
# Demodulating Decimating Integrator Channel

This block is one channel of an accumulate-and-dump decimation filter used for resolver sensing. It takes a stream of signed samples, qualified by a valid strobe, from one of two sources. One is a converter path that can optionally flip the sample's top bit to turn offset-binary data into two's complement. The other is a software path with its own data word and update strobe. Only the selected source is heard and the other is ignored.

Each accepted sample can be demodulated against the polarity of an excitation reference: it is negated while the reference is negative. It is then integrated by a first-order or second-order integrator. The window length is programmed as "samples minus one". When the window closes, the result is posted to an output register, a done flag rises and a one-cycle interrupt pulse is raised. Reading the output clears the done flag. The integrators clear at each dump so that the next window begins on the very next sample.

Top module: `demod_decim_chan`

## Requirements
- R1: A window holds `cfg_len_m1 + 1` accepted samples; with `cfg_len_m1 = 0` every accepted sample produces its own result.
- R2: With `cfg_order = 0` the result is the plain sum of the window's samples. With `cfg_order = 1` the result is the sum of the window's running partial sums, i.e. for samples x1..xN it is Σ_k Σ_{j≤k} xj.
- R3: When `cfg_demod_en = 1` and `cfg_pol_sel = 1`, a sample accepted while `exc_pol = 0` (negative reference) is negated, and one accepted while `exc_pol = 1` passes unchanged. If either control bit is 0, samples pass unchanged.
- R4: On the converter path with `cfg_sign_cvt = 1`, bit 15 of `adc_data` is inverted before use, so 16'h8000 reads as 0 and 16'h0000 reads as -32768. The software path is never converted.
- R5: In the clock cycle after the edge that accepts a window's last sample, `out_data` holds the result, `done` is 1 and `irq` is 1 for exactly that one cycle. `out_data` does not change in any other cycle.
- R6: A cycle with `out_read = 1` clears `done` at that edge. If a result is posted at the same edge, `done` stays 1.
- R7: With `cfg_src_adc = 1`, only `adc_valid`/`adc_data` feed the filter and `sw_update`/`sw_data` have no effect. With `cfg_src_adc = 0` the reverse holds.
- R8: Windows follow each other with no gap. With a sample on every cycle, consecutive results are the sums of consecutive disjoint groups of samples.
- R9: While `cfg_enable = 0`, partial sums are discarded, the window count restarts, `done` is 0 and `irq` stays 0. `out_data` keeps its last value.
- R10: At the longest window (`cfg_len_m1 = 4095`) with full-scale samples, the result is exact in both orders (no wrap in the 40-bit result).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Filter on; low holds integrators, counter and done clear |
| cfg_src_adc | input | 1 | 1 = converter path, 0 = software path |
| cfg_len_m1 | input | 12 | Window length minus one |
| cfg_order | input | 1 | 0 = first order, 1 = second order |
| cfg_demod_en | input | 1 | Demodulation enable |
| cfg_pol_sel | input | 1 | Demodulate by excitation polarity |
| cfg_sign_cvt | input | 1 | Invert MSB of converter samples |
| adc_valid | input | 1 | Converter sample strobe |
| adc_data | input | 16 | Converter sample |
| exc_pol | input | 1 | Excitation polarity, 1 = positive |
| sw_update | input | 1 | Software sample strobe |
| sw_data | input | 16 | Software sample word (signed) |
| out_read | input | 1 | Output read strobe, clears done |
| out_data | output | 40 | Posted result (signed) |
| done | output | 1 | Result available |
| irq | output | 1 | One-cycle pulse per posted result |

## Verification
Mixed-sign and ramp windows are fed through both orders, because a ramp gives different first- and second-order sums and so shows whether the stage chain is ordered correctly. A constant sample with an alternating reference polarity separates true demodulation from pass-through. Offset-binary edge codes show whether the MSB flip applies on the right path. A sample on every cycle, with short windows, exposes any lost or duplicated sample at the window boundaries. Full-scale samples at the longest window show any truncation of the result width.

// File: rtl/ddi_pkg.sv
// Package: shared sizing for the demodulating decimating integrator.
// Assumes at most two integrator stages are ever selected.
package ddi_pkg;
    localparam int ORDER_MAX = 2;

    // Result width so that the longest window cannot wrap at the highest order.
    function automatic int acc_width(input int data_w, input int len_w);
        return data_w + 1 + ORDER_MAX * len_w;
    endfunction
endpackage

// File: rtl/ddi_condition.sv
// Module: source select, optional MSB flip and polarity demodulation.
// Produces one conditioned signed sample, one bit wider than the input so
// that negating the most negative code cannot overflow. Purely combinational.
module ddi_condition #(
    parameter int DATA_W = 16
) (
    input  logic              src_adc,
    input  logic              sign_cvt,
    input  logic              demod_en,
    input  logic              pol_sel,
    input  logic              exc_pol,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              sw_update,
    input  logic [DATA_W-1:0] sw_data,
    output logic              smp_valid,
    output logic signed [DATA_W:0] smp_value
);
    logic [DATA_W-1:0] raw;
    logic signed [DATA_W:0] ext;

    // Pick the active source and apply the offset-binary flip on the converter path.
    always_comb begin
        if (src_adc) begin
            smp_valid = adc_valid;
            raw       = adc_data;
            if (sign_cvt) begin
                raw[DATA_W-1] = ~adc_data[DATA_W-1];
            end
        end else begin
            smp_valid = sw_update;
            raw       = sw_data;
        end
    end

    // Sign-extend, then negate while the excitation reference is negative.
    always_comb begin
        ext = {raw[DATA_W-1], raw};
        if (demod_en && pol_sel && !exc_pol) begin
            smp_value = -ext;
        end else begin
            smp_value = ext;
        end
    end
endmodule

// File: rtl/ddi_window.sv
// Module: decimation down-counter. Loaded with length-minus-one, steps once
// per accepted sample, flags the last sample of a window and reloads then.
// Held at the reload value while disabled.
module ddi_window #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] remain;

    assign last = (remain == '0);

    // Count down per sample, reloading at window end or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            remain <= len_m1;
        end else if (step) begin
            if (last) begin
                remain <= len_m1;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddi_integrator.sv
// Module: cascade of integrator stages with a dump-and-clear.
// Stage i adds the updated output of stage i-1; result picks the stage
// chosen by the order bit and includes the sample presented this cycle.
module ddi_integrator #(
    parameter int IN_W  = 17,
    parameter int ACC_W = 41
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic                    dump,
    input  logic                    order,
    input  logic signed [IN_W-1:0]  sample,
    output logic signed [ACC_W-1:0] result
);
    import ddi_pkg::*;

    logic signed [ACC_W-1:0] acc  [ORDER_MAX];
    logic signed [ACC_W-1:0] nxt  [ORDER_MAX];
    logic signed [ACC_W-1:0] s_ext;

    assign s_ext = ACC_W'(sample);

    for (genvar g = 0; g < ORDER_MAX; g++) begin : g_stage
        // Next value of this stage given the stage before it.
        if (g == 0) begin : g_first
            always_comb nxt[g] = acc[g] + s_ext;
        end else begin : g_rest
            always_comb nxt[g] = acc[g] + nxt[g-1];
        end

        // Hold, accumulate or clear this stage.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc[g] <= '0;
            end else if (step) begin
                acc[g] <= dump ? '0 : nxt[g];
            end
        end
    end

    // Select the stage that corresponds to the programmed order.
    always_comb result = order ? nxt[ORDER_MAX-1] : nxt[0];
endmodule

// File: rtl/demod_decim_chan.sv
// Module: top of the demodulating decimating integrator channel.
// Conditions each accepted sample, integrates it, and posts the result with
// a done flag and an interrupt pulse when the window counter expires.
// Assumes configuration is stable while enabled.
module demod_decim_chan #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 12,
    localparam int ACC_W = ddi_pkg::acc_width(DATA_W, LEN_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_src_adc,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              cfg_order,
    input  logic              cfg_demod_en,
    input  logic              cfg_pol_sel,
    input  logic              cfg_sign_cvt,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              exc_pol,
    input  logic              sw_update,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              out_read,
    output logic [ACC_W-1:0]  out_data,
    output logic              done,
    output logic              irq
);
    logic                    smp_valid;
    logic signed [DATA_W:0]  smp_value;
    logic                    step;
    logic                    last;
    logic                    dump;
    logic signed [ACC_W-1:0] result;

    ddi_condition #(.DATA_W(DATA_W)) u_cond (
        .src_adc   (cfg_src_adc),
        .sign_cvt  (cfg_sign_cvt),
        .demod_en  (cfg_demod_en),
        .pol_sel   (cfg_pol_sel),
        .exc_pol   (exc_pol),
        .adc_valid (adc_valid),
        .adc_data  (adc_data),
        .sw_update (sw_update),
        .sw_data   (sw_data),
        .smp_valid (smp_valid),
        .smp_value (smp_value)
    );

    assign step = cfg_enable && smp_valid;
    assign dump = step && last;

    ddi_window #(.LEN_W(LEN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_enable),
        .len_m1 (cfg_len_m1),
        .step   (step),
        .last   (last)
    );

    ddi_integrator #(.IN_W(DATA_W + 1), .ACC_W(ACC_W)) u_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!cfg_enable),
        .step   (step),
        .dump   (dump),
        .order  (cfg_order),
        .sample (smp_value),
        .result (result)
    );

    // Post the result on a dump; the register keeps it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (dump) begin
            out_data <= result;
        end
    end

    // Done flag: set on dump, cleared by a read or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            done <= 1'b0;
        end else if (dump) begin
            done <= 1'b1;
        end else if (out_read) begin
            done <= 1'b0;
        end
    end

    // One-cycle interrupt pulse per posted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= dump;
        end
    end
endmodule

// File: rtl/ddi_channel_chk.sv
// Checker: temporal properties of the channel's output handshake.
// Attached to every instance of the top module by the bind below.
module ddi_channel_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_src_adc,
    input logic             adc_valid,
    input logic             sw_update,
    input logic             out_read,
    input logic [ACC_W-1:0] out_data,
    input logic             done,
    input logic             irq
);
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done); // R5

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(out_data)); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_read) |=> (!done || irq)); // R6

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!done && !irq)); // R9

    AST_IRQ_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_enable && (cfg_src_adc ? adc_valid : sw_update))); // R7
endmodule

bind demod_decim_chan ddi_channel_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_src_adc (cfg_src_adc),
    .adc_valid   (adc_valid),
    .sw_update   (sw_update),
    .out_read    (out_read),
    .out_data    (out_data),
    .done        (done),
    .irq         (irq)
);

// File: tb/demod_decim_chan_test.sv
// Directed bench for the demodulating decimating integrator channel.
module demod_decim_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_enable = 1'b0;
    logic             cfg_src_adc = 1'b1;
    logic [11:0]      cfg_len_m1 = '0;
    logic             cfg_order = 1'b0;
    logic             cfg_demod_en = 1'b0;
    logic             cfg_pol_sel = 1'b0;
    logic             cfg_sign_cvt = 1'b0;
    logic             adc_valid = 1'b0;
    logic [15:0]      adc_data = '0;
    logic             exc_pol = 1'b1;
    logic             sw_update = 1'b0;
    logic [15:0]      sw_data = '0;
    logic             out_read = 1'b0;
    logic [ACC_W-1:0] out_data;
    logic             done;
    logic             irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    demod_decim_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_adc(cfg_src_adc),
        .cfg_len_m1(cfg_len_m1), .cfg_order(cfg_order), .cfg_demod_en(cfg_demod_en),
        .cfg_pol_sel(cfg_pol_sel), .cfg_sign_cvt(cfg_sign_cvt), .adc_valid(adc_valid),
        .adc_data(adc_data), .exc_pol(exc_pol), .sw_update(sw_update), .sw_data(sw_data),
        .out_read(out_read), .out_data(out_data), .done(done), .irq(irq)
    );

    function automatic longint outv();
        longint v;
        v = $signed(out_data);
        return v;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One converter sample; returns at the negedge after it was taken.
    task automatic push_adc(input logic [15:0] d, input logic p);
        @(negedge clk);
        adc_valid = 1'b1; adc_data = d; exc_pol = p;
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    task automatic push_sw(input logic [15:0] d);
        @(negedge clk);
        sw_update = 1'b1; sw_data = d;
        @(negedge clk);
        sw_update = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        out_read = 1'b1;
        @(negedge clk);
        out_read = 1'b0;
    endtask

    task automatic restart(input logic [11:0] lm1, input logic ord);
        @(negedge clk);
        cfg_enable = 1'b0; cfg_len_m1 = lm1; cfg_order = ord;
        @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    task automatic t_reset();
        chk("R5 reset out_data", outv(), 0);
        chk("R5 reset done", done, 0);
        chk("R5 reset irq", irq, 0);
    endtask

    task automatic t_first_order();
        restart(12'd3, 1'b0);
        push_adc(16'd10, 1'b1); push_adc(16'd20, 1'b1); push_adc(-16'sd5, 1'b1);
        chk("R1 no early done", done, 0);
        push_adc(16'd7, 1'b1);
        chk("R2 first order sum", outv(), 32);
        chk("R5 done set", done, 1);
        chk("R5 irq pulse", irq, 1);
        @(negedge clk);
        chk("R5 irq one cycle", irq, 0);
        chk("R5 out held", outv(), 32);
    endtask

    task automatic t_second_order();
        longint part = 0, tot = 0;
        restart(12'd3, 1'b1);
        for (int k = 1; k <= 4; k++) begin
            push_adc(16'(k), 1'b1);
            part += k; tot += part;
        end
        chk("R2 second order", outv(), tot);
    endtask

    task automatic t_read_clear();
        do_read();
        chk("R6 read clears done", done, 0);
        restart(12'd0, 1'b0);
        push_adc(16'd9, 1'b1);
        chk("R1 len one result", outv(), 9);
        @(negedge clk);
        adc_valid = 1'b1; adc_data = 16'd4; out_read = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0; out_read = 1'b0;
        chk("R6 new result wins", done, 1);
        chk("R6 new result value", outv(), 4);
    endtask

    task automatic t_demod();
        cfg_demod_en = 1'b1; cfg_pol_sel = 1'b1;
        restart(12'd3, 1'b0);
        push_adc(16'd100, 1'b1); push_adc(16'd100, 1'b0);
        push_adc(16'd100, 1'b1); push_adc(16'd100, 1'b1);
        chk("R3 demod by polarity", outv(), 200);
        cfg_pol_sel = 1'b0;
        restart(12'd3, 1'b0);
        push_adc(16'd100, 1'b1); push_adc(16'd100, 1'b0);
        push_adc(16'd100, 1'b1); push_adc(16'd100, 1'b0);
        chk("R3 pol_sel off passes", outv(), 400);
        cfg_demod_en = 1'b0;
    endtask

    task automatic t_sign_cvt();
        cfg_sign_cvt = 1'b1;
        restart(12'd1, 1'b0);
        push_adc(16'h8005, 1'b1); push_adc(16'h0000, 1'b1);
        chk("R4 msb flip", outv(), 5 - 32768);
        cfg_src_adc = 1'b0;
        restart(12'd0, 1'b0);
        push_sw(16'h8005);
        chk("R4 sw path unconverted", outv(), -32763);
        cfg_src_adc = 1'b1; cfg_sign_cvt = 1'b0;
    endtask

    task automatic t_source();
        restart(12'd0, 1'b0);
        push_adc(16'd11, 1'b1);
        do_read();
        push_sw(16'd55);
        chk("R7 sw ignored done", done, 0);
        chk("R7 sw ignored out", outv(), 11);
        cfg_src_adc = 1'b0;
        restart(12'd0, 1'b0);
        push_adc(16'd77, 1'b1);
        chk("R7 adc ignored", outv(), 11);
        push_sw(16'd55);
        chk("R7 sw path used", outv(), 55);
        cfg_src_adc = 1'b1;
    endtask

    task automatic t_back_to_back();
        restart(12'd1, 1'b0);
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            if (k > 0 && k % 2 == 0) begin
                chk("R8 window value", outv(), longint'(2 * k - 1));
                chk("R8 window irq", irq, 1);
            end else if (k > 0) begin
                chk("R8 mid window irq", irq, 0);
            end
            if (k < 6) begin
                adc_valid = 1'b1; adc_data = 16'(k + 1);
            end else begin
                adc_valid = 1'b0;
            end
        end
    endtask

    task automatic t_disable();
        restart(12'd3, 1'b0);
        do_read();
        push_adc(16'd1000, 1'b1); push_adc(16'd1000, 1'b1);
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        adc_valid = 1'b1; adc_data = 16'd500;
        @(negedge clk);
        adc_valid = 1'b0;
        chk("R9 no irq while off", irq, 0);
        chk("R9 done low while off", done, 0);
        chk("R9 out kept", outv(), 11);
        cfg_enable = 1'b1;
        for (int k = 1; k <= 4; k++) push_adc(16'(k), 1'b1);
        chk("R9 partial discarded", outv(), 10);
    endtask

    task automatic t_full_scale(input logic ord, input logic [15:0] d);
        longint part = 0, tot = 0;
        restart(12'd4095, ord);
        @(negedge clk);
        adc_valid = 1'b1; adc_data = d;
        for (int k = 0; k < 4096; k++) begin
            part += longint'($signed(d)); tot += part;
            @(negedge clk);
        end
        adc_valid = 1'b0;
        chk("R10 full scale", outv(), ord ? tot : part);
        chk("R10 full scale irq", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_first_order();
        t_second_order();
        t_read_clear();
        t_demod();
        t_sign_cvt();
        t_source();
        t_back_to_back();
        t_disable();
        t_full_scale(1'b0, 16'h7FFF);
        t_full_scale(1'b1, 16'h8000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule